// File: doc/BRIEF.md
# Microwire Serial Memory Slave

This block is the serial-side logic of a 4 kbit nonvolatile memory that is reached over a three-wire Microwire link. The link has a select line, a serial clock and a data-in line, plus one data-out line. The select line is active high. The data-out line is modelled as a value and an output enable, so the pad ring can build the tri-state driver. All pins are sampled on the system clock. A rising edge of the serial clock is detected when the pin is seen high one cycle after it was seen low. The array is a register file. It holds 256 words of 16 bits or 512 bytes of 8 bits, chosen by a parameter.

An instruction is framed as follows. While selected, the host clocks in a start bit of 1, then a 2-bit opcode, then an address field. The address field is 8 bits wide in word organisation and 9 bits wide in byte organisation. Reads return a dummy zero and then the addressed data. Writes and erases are collected while the device is selected. They are committed when the select line falls. Committing starts a self-timed programming period, which is a counter of system clocks. While that period runs, a selected but idle device reports its status on the data-out line.

Top module: `mw_eeprom`

## Requirements
- R1: While selected, 0 bits seen before the first 1 are ignored. An instruction is a start bit 1, then the opcode (first bit sent is the most significant), then the address field, most significant bit first. The address field is 8 bits wide with the default word organisation.
- R2: Opcode 10 reads. The serial-clock rise that samples the last address bit makes `so` drive a 0 with `so_en` high. Each of the next DW rises drives the next bit of the addressed word, most significant bit first. The rise after the last data bit drops `so_en`.
- R3: `so_en` is low whenever `cs` is low. It is also low while the opcode and address bits of an instruction are being received.
- R4: After reset, writing is disabled. Opcode 00 with address top bits 11 enables writing, and opcode 00 with top bits 00 disables it. While writing is disabled, write, erase, erase-all and write-all change no word and start no busy period.
- R5: Opcode 01 stores the data words that follow when `cs` falls. Word k goes to the address that keeps the upper bits of the start address and sets the low 3 bits to (start + k) mod 8. A later word that lands in the same slot replaces the earlier one. A trailing incomplete word is discarded.
- R6: After reset every word reads all ones. Opcode 11 sets the addressed word to all ones. Opcode 00 with top bits 10 sets every word to all ones. Opcode 00 with top bits 01, followed by one data word, writes that word to every address.
- R7: A committed write or erase starts a busy period of BUSY_CYCLES clocks. During that period, a selected device with no instruction in progress drives `so_en` high with `so` low. Once the period ends it drives `so` high.
- R8: A start bit that arrives during the busy period is ignored. The instruction that follows it neither reads nor changes the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high; its falling edge commits writes |
| sk | input | 1 | Serial clock; data moves on its rising edge |
| di | input | 1 | Serial data in |
| so | output | 1 | Serial data out value (read data or ready status) |
| so_en | output | 1 | Output enable for `so`; low means high impedance |

## Verification
Suppose the frame counter is off by one, or the page slot pointer is wrong. Then the dummy zero or the status bit shows up on the wrong serial-clock rise, or a word read back differs from the model, at the first read after the bad write. A wrong enable or pending-operation state shows in two ways: a status poll sees `so_en` high when it should be low (or the reverse) right after the select line rises, or a later read returns changed data. A busy counter with the wrong length moves the clock at which `so` turns high. The bench measures that clock from the falling edge of `cs`, within a few cycles.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter bit ORG16       = 1'b1,
  parameter int MEM_BITS    = 4096,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic so,
  output logic so_en
);

  localparam int DW    = ORG16 ? 16 : 8;
  localparam int WORDS = MEM_BITS / DW;
  localparam int AW    = $clog2(WORDS);
  localparam int CW    = 2 + AW;
  localparam int PW    = PAGE_BYTES * 8 / DW;
  localparam int PB    = $clog2(PW);
  localparam int MAXN  = (DW > CW) ? DW : CW;
  localparam int CNW   = $clog2(MAXN + 1);
  localparam int BCW   = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_RD, S_WD, S_HOLD} st_t;
  typedef enum logic [2:0] {P_NONE, P_WRITE, P_ERASE, P_ERAL, P_WRAL} pend_t;

  st_t              st;
  pend_t            pend;
  logic             sk_d, cs_d;
  logic [CW-2:0]    cmd;
  logic [CNW-1:0]   cnt;
  logic [DW-1:0]    rsh, wsh;
  logic [AW-1:0]    addr;
  logic [PB-1:0]    slot;
  logic [DW-1:0]    pbuf [PW];
  logic [PW-1:0]    vld;
  logic             wen, poll, rd_oe, so_r;
  logic [BCW-1:0]   busy_cnt;
  logic [DW-1:0]    mem [WORDS];

  logic             busy, sk_rise, cs_fall, in_idle, commit_ok, commit;
  logic [CW-1:0]    full;
  logic [1:0]       op;
  logic [AW-1:0]    fa;
  logic [DW-1:0]    wsh_n;

  assign busy    = busy_cnt != '0;
  assign sk_rise = cs & sk & ~sk_d;
  assign cs_fall = cs_d & ~cs;
  assign in_idle = st == S_IDLE;
  assign full    = {cmd, di};
  assign op      = full[CW-1:CW-2];
  assign fa      = full[AW-1:0];
  assign wsh_n   = {wsh[DW-2:0], di};

  always_comb begin
    case (pend)
      P_WRITE:         commit_ok = |vld;
      P_ERASE, P_ERAL: commit_ok = 1'b1;
      P_WRAL:          commit_ok = vld[0];
      default:         commit_ok = 1'b0;
    endcase
  end

  assign commit = cs_fall & wen & commit_ok;

  assign so_en = cs & (rd_oe | (poll & in_idle));
  assign so    = rd_oe ? so_r : ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pend     <= P_NONE;
      sk_d     <= 1'b0;
      cs_d     <= 1'b0;
      cmd      <= '0;
      cnt      <= '0;
      rsh      <= '0;
      wsh      <= '0;
      addr     <= '0;
      slot     <= '0;
      vld      <= '0;
      wen      <= 1'b0;
      poll     <= 1'b0;
      rd_oe    <= 1'b0;
      so_r     <= 1'b0;
      busy_cnt <= '0;
    end else begin
      sk_d <= sk;
      cs_d <= cs;
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (cs_fall) begin
        st    <= S_IDLE;
        rd_oe <= 1'b0;
        pend  <= P_NONE;
        vld   <= '0;
        if (commit) begin
          busy_cnt <= BCW'(BUSY_CYCLES);
          poll     <= 1'b1;
        end
      end else if (sk_rise) begin
        case (st)
          S_IDLE: if (di && !busy) begin
            st   <= S_CMD;
            cnt  <= '0;
            poll <= 1'b0;
          end
          S_CMD: begin
            cmd <= full[CW-2:0];
            if (cnt == CNW'(CW - 1)) begin
              cnt <= '0;
              case (op)
                2'b10: begin
                  st    <= S_RD;
                  rd_oe <= 1'b1;
                  so_r  <= 1'b0;
                  rsh   <= mem[fa];
                end
                2'b01: begin
                  st   <= S_WD;
                  pend <= P_WRITE;
                  addr <= fa;
                  slot <= fa[PB-1:0];
                end
                2'b11: begin
                  st   <= S_HOLD;
                  pend <= P_ERASE;
                  addr <= fa;
                end
                default: begin
                  case (fa[AW-1:AW-2])
                    2'b11: begin wen <= 1'b1;    st <= S_HOLD; end
                    2'b00: begin wen <= 1'b0;    st <= S_HOLD; end
                    2'b10: begin pend <= P_ERAL; st <= S_HOLD; end
                    default: begin
                      pend <= P_WRAL;
                      st   <= S_WD;
                      slot <= '0;
                    end
                  endcase
                end
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RD: begin
            if (cnt == CNW'(DW)) begin
              rd_oe <= 1'b0;
              st    <= S_HOLD;
            end else begin
              so_r <= rsh[DW-1];
              rsh  <= {rsh[DW-2:0], 1'b0};
              cnt  <= cnt + 1'b1;
            end
          end
          S_WD: begin
            wsh <= wsh_n;
            if (cnt == CNW'(DW - 1)) begin
              cnt        <= '0;
              pbuf[slot] <= wsh_n;
              vld[slot]  <= 1'b1;
              if (pend == P_WRITE) slot <= slot + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (commit) begin
      case (pend)
        P_WRITE:
          for (int i = 0; i < PW; i++)
            if (vld[i]) mem[{addr[AW-1:PB], PB'(i)}] <= pbuf[i];
        P_ERASE: mem[addr] <= '1;
        P_ERAL:  for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        P_WRAL:  for (int i = 0; i < WORDS; i++) mem[i] <= pbuf[0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs,
  input logic        cs_d,
  input logic        wen,
  input logic        idle,
  input logic [2:0]  pend,
  input logic        rd_oe,
  input logic        so,
  input logic [31:0] busy_cnt
);

  a_r7_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != 0) |=> (busy_cnt == $past(busy_cnt) - 1));

  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != 0) |-> (idle && pend == 3'd0));

  a_r4_disabled_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_d && !cs && !wen && busy_cnt == 0) |=> (busy_cnt == 0));

  a_r2_dummy_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_oe) |-> !so);

  a_r3_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs) |=> !rd_oe);

endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs       (cs),
  .cs_d     (cs_d),
  .wen      (wen),
  .idle     (in_idle),
  .pend     (pend),
  .rd_oe    (rd_oe),
  .so       (so),
  .busy_cnt (32'(busy_cnt))
);

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
  localparam int B     = 300;
  localparam int DW    = 16;
  localparam int WORDS = 256;
  localparam int AW    = 8;
  localparam int PW    = 8;
  localparam int PB    = 3;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic so, so_en;
  int   tests = 0, fails = 0, cyc = 0;
  bit   done = 1'b0;
  bit   wen_m = 1'b0;
  logic [DW-1:0] model [WORDS];

  always #2 clk = ~clk;

  mw_eeprom #(.ORG16(1'b1), .BUSY_CYCLES(B)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .so(so), .so_en(so_en));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  function automatic logic [AW-1:0] paddr(input logic [AW-1:0] a, input int k);
    logic [PB-1:0] lo;
    lo = a[PB-1:0] + PB'(k);
    return {a[AW-1:PB], lo};
  endfunction

  task automatic bit_io(input logic b, output logic o, output logic oe);
    @(negedge clk); di = b; sk = 1'b1;
    @(negedge clk); o = so; oe = so_en;
    @(negedge clk); sk = 1'b0;
    @(negedge clk);
  endtask

  task automatic select_dev;
    @(negedge clk); cs = 1'b1;
  endtask

  task automatic deselect(output int t);
    @(negedge clk); cs = 1'b0; sk = 1'b0; t = cyc;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] a, input int lead,
                          input bit quiet_chk, output logic lo, output logic loe);
    logic o, oe, any_oe;
    any_oe = 1'b0;
    for (int i = 0; i < lead; i++) bit_io(1'b0, o, oe);
    bit_io(1'b1, o, oe);
    bit_io(op[1], o, oe); any_oe |= oe;
    bit_io(op[0], o, oe); any_oe |= oe;
    for (int i = AW - 1; i > 0; i--) begin
      bit_io(a[i], o, oe);
      any_oe |= oe;
    end
    if (quiet_chk) check("R3 so_en low while instruction bits arrive", any_oe, 0);
    bit_io(a[0], lo, loe);
  endtask

  task automatic send_word(input logic [DW-1:0] w);
    logic o, oe;
    for (int i = DW - 1; i >= 0; i--) bit_io(w[i], o, oe);
  endtask

  task automatic read_word(input logic [AW-1:0] a, input int lead, output logic [DW-1:0] d);
    logic o, oe, lo, loe, all_oe;
    int t;
    all_oe = 1'b1;
    d = '0;
    select_dev();
    send_cmd(2'b10, a, lead, 1'b1, lo, loe);
    check("R2 dummy zero after last address bit", {30'd0, loe, lo}, 32'd2);
    for (int i = 0; i < DW; i++) begin
      bit_io(1'b0, o, oe);
      d = {d[DW-2:0], o};
      all_oe &= oe;
    end
    check("R2 data driven for all bits", all_oe, 1);
    bit_io(1'b0, o, oe);
    check("R2 released after last data bit", oe, 0);
    deselect(t);
    check("R3 so_en low when deselected", so_en, 0);
  endtask

  task automatic check_read(input logic [AW-1:0] a, input int lead, input string req);
    logic [DW-1:0] d;
    read_word(a, lead, d);
    check(req, d, model[a]);
  endtask

  task automatic write_rand(input logic [AW-1:0] a, input int n, input int extra, output int t);
    logic lo, loe, o, oe;
    logic [DW-1:0] w;
    select_dev();
    send_cmd(2'b01, a, 0, 1'b1, lo, loe);
    for (int k = 0; k < n; k++) begin
      w = DW'($urandom);
      send_word(w);
      if (wen_m) model[paddr(a, k)] = w;
    end
    for (int k = 0; k < extra; k++) bit_io(1'b0, o, oe);
    deselect(t);
  endtask

  task automatic erase_one(input logic [AW-1:0] a, output int t);
    logic lo, loe;
    select_dev();
    send_cmd(2'b11, a, 0, 1'b1, lo, loe);
    deselect(t);
    if (wen_m) model[a] = '1;
  endtask

  task automatic ext_cmd(input logic [1:0] code, output int t);
    logic lo, loe;
    select_dev();
    send_cmd(2'b00, {code, {(AW-2){1'b0}}}, 0, 1'b1, lo, loe);
    deselect(t);
    if (code == 2'b11) wen_m = 1'b1;
    if (code == 2'b00) wen_m = 1'b0;
    if (code == 2'b10 && wen_m) for (int i = 0; i < WORDS; i++) model[i] = '1;
  endtask

  task automatic write_all(input logic [DW-1:0] w, output int t);
    logic lo, loe;
    select_dev();
    send_cmd(2'b00, {2'b01, {(AW-2){1'b0}}}, 0, 1'b1, lo, loe);
    send_word(w);
    deselect(t);
    if (wen_m) for (int i = 0; i < WORDS; i++) model[i] = w;
  endtask

  task automatic wait_ready(input int t0);
    int n, el, t;
    select_dev();
    @(negedge clk);
    check("R7 status driven and busy right after commit", {30'd0, so_en, so}, 32'd2);
    n = 0;
    while (so !== 1'b1 && n < B + 50) begin
      @(negedge clk);
      n++;
    end
    el = cyc - t0;
    check("R7 ready after busy period", (el >= B - 1 && el <= B + 4), 1);
    check("R7 status still enabled when ready", so_en, 1);
    deselect(t);
  endtask

  task automatic no_status(input string req);
    int t;
    select_dev();
    @(negedge clk);
    check(req, so_en, 0);
    deselect(t);
  endtask

  initial begin
    int t, t0, r;
    logic [AW-1:0] a;
    logic [DW-1:0] d, dd;
    logic lo, loe, o, oe;
    void'($urandom(32'h1d2c));
    for (int i = 0; i < WORDS; i++) model[i] = '1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    check("R3 so_en low after reset", so_en, 0);
    no_status("R3 no status output before any write");
    check_read(8'h00, 0, "R6 reset contents all ones");
    check_read(8'h00, 3, "R1 leading zeros before start ignored");

    write_rand(8'h05, 1, 0, t);
    no_status("R4 write ignored after power-up: no busy");
    check_read(8'h05, 0, "R4 word unchanged while disabled");

    ext_cmd(2'b11, t);
    write_rand(8'h05, 1, 0, t0);
    wait_ready(t0);
    check_read(8'h05, 1, "R5 single word write");

    write_rand(8'h09, 1, 0, t0);
    dd = model[9];
    select_dev();
    send_cmd(2'b01, 8'h09, 0, 1'b0, lo, loe);
    send_word(~dd);
    deselect(t);
    select_dev();
    send_cmd(2'b10, 8'h05, 0, 1'b0, lo, loe);
    d = '0;
    for (int i = 0; i < DW; i++) begin
      bit_io(1'b0, o, oe);
      d = {d[DW-2:0], o};
    end
    deselect(t);
    check("R8 read while busy shows only busy status", d, 0);
    wait_ready(t0);
    check_read(8'h09, 0, "R8 write while busy ignored");

    write_rand(8'h16, 3, 0, t0);
    wait_ready(t0);
    check_read(8'h16, 0, "R5 page word 0");
    check_read(8'h17, 0, "R5 page word 1");
    check_read(8'h10, 0, "R5 page wraps to page start");
    check_read(8'h18, 0, "R5 next page untouched");

    write_rand(8'h20, 1, 5, t0);
    wait_ready(t0);
    check_read(8'h20, 0, "R5 full word before partial");
    check_read(8'h21, 0, "R5 partial trailing word discarded");

    write_rand(8'h30, PW + 2, 0, t0);
    wait_ready(t0);
    check_read(8'h30, 0, "R5 overwritten slot keeps last word");
    check_read(8'h31, 0, "R5 overwritten slot keeps last word");
    check_read(8'h37, 0, "R5 page end");

    erase_one(8'h16, t0);
    wait_ready(t0);
    check_read(8'h16, 0, "R6 erase sets all ones");
    check_read(8'h17, 0, "R6 erase leaves neighbour");

    write_all(16'h3C3C, t0);
    wait_ready(t0);
    check_read(8'h00, 0, "R6 write-all first word");
    check_read(8'hFF, 0, "R6 write-all last word");

    ext_cmd(2'b00, t);
    ext_cmd(2'b10, t);
    no_status("R4 erase-all ignored while disabled");
    check_read(8'h42, 0, "R4 data kept after ignored erase-all");
    erase_one(8'h42, t);
    no_status("R4 erase ignored while disabled");
    check_read(8'h42, 0, "R4 data kept after ignored erase");

    ext_cmd(2'b11, t);
    ext_cmd(2'b10, t0);
    wait_ready(t0);
    check_read(8'h42, 0, "R6 erase-all gives all ones");

    for (int it = 0; it < 40; it++) begin
      r = $urandom % 6;
      a = AW'($urandom);
      case (r)
        0, 1: check_read(a, $urandom % 3, "R2 random read matches model");
        2: begin
          write_rand(a, 1 + $urandom % (PW + 2), 0, t0);
          if (wen_m) wait_ready(t0);
          else no_status("R4 random write ignored while disabled");
        end
        3: begin
          erase_one(a, t0);
          if (wen_m) wait_ready(t0);
          else no_status("R4 random erase ignored while disabled");
        end
        4: ext_cmd(2'b11, t);
        default: if ($urandom % 3 == 0) ext_cmd(2'b00, t); else ext_cmd(2'b11, t);
      endcase
    end

    check_read(8'h05, 0, "R2 final read");
    finish_run();
  end
endmodule